// File: doc/BRIEF.md
# Multiplexed ADC Scan Sequencer

This block drives one shared successive-approximation converter across several multiplexed analog inputs. A programmable power-of-two divider turns the system clock into conversion ticks. On each tick the sequencer either settles the multiplexer, runs one step of a binary search against an external comparator, or writes back a finished result. The enabled channels are scanned without pause in ascending round-robin order, and the newest 10-bit code for each channel is kept in its own result register.

A run control lets software freeze the scan. While frozen no conversion is in flight, so every result register holds still and can be read without tearing. A conversion that is cut short by a freeze is dropped and does not touch any register. Each completed write raises a one-cycle strobe that carries the channel index. A downstream limit checker can use it.

Top module: `adc_scan_seq`

## Requirements
- R1: With divider code k from 1 to 7, one conversion tick occurs every 2^(k-1) system clocks. One conversion takes 12 ticks, so while a single channel is scanned, consecutive result writes are exactly 12*2^(k-1) clocks apart.
- R2: Divider code 0 stops the ticks. While run is 1, no result write occurs and the results hold.
- R3: Channel 0 (bit 0 of `chan_en`) gates the scan. While it is 0, no channel converts, whatever the other enable bits are.
- R4: Enabled channels are converted in ascending index order, wrapping from the highest enabled index back to the lowest, and disabled channels are skipped.
- R5: `cmp_ge` is 1 when the selected input is at or above `trial_code`. The search starts at the MSB and decides one bit per tick, so the stored result equals the input's 10-bit code, from 0 to 1023.
- R6: While run is 0, no result write occurs and every result register keeps its last completed value.
- R7: A conversion in progress when run falls is abandoned. After run returns to 1, the first result written for that channel comes from a fresh conversion.
- R8: Each result write raises `wr_strobe` for exactly one cycle, with `wr_chan` naming the channel. The new value is visible in the result vector in that same cycle.
- R9: After reset, every result register is 0 and `wr_strobe` is 0.
- R10: A write to one channel leaves the result registers of all other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 3 | Divider code; 0 stops ticks, k divides by 2^(k-1) |
| chan_en | input | 4 | Per-channel enable; bit 0 gates all channels |
| run | input | 1 | 1 scans continuously, 0 freezes |
| cmp_ge | input | 1 | Comparator result: selected input >= trial_code |
| mux_sel | output | 2 | Analog multiplexer channel select |
| trial_code | output | 10 | Trial code for the converter DAC |
| result_flat | output | 40 | Result registers; channel i at bits [10*i +: 10] |
| wr_strobe | output | 1 | One-cycle pulse on each result write |
| wr_chan | output | 2 | Channel index for the write flagged by wr_strobe |

## Verification
A corrupted search accumulator shows up as a wrong code in the very next write for that channel, at most 12 ticks later. A skipped or repeated channel breaks the strobe index order within one scan round. A divider counter off by one, or a tick lost in the step sequence, changes the spacing between strobes on the first steady interval. A conversion that is resumed when it should have been dropped leaves stale MSB decisions in place, so the first result after an unfreeze comes out wrong.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_TRIAL  = 2'd2,
    PH_WRITE  = 2'd3
  } scan_phase_e;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_code,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_m1;

  always_comb begin
    lim_m1 = '0;
    if (div_code != '0) begin
      lim_m1 = CNT_W'((64'd1 << (div_code - 1'b1)) - 64'd1);
    end
  end

  always_comb begin
    tick  = 1'b0;
    cnt_d = cnt_q;
    if (div_code == '0) begin
      cnt_d = '0;
    end else if (cnt_q >= lim_m1) begin
      tick  = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH-1:0]         mask,
  input  logic [$clog2(NUM_CH)-1:0] cur,
  output logic [$clog2(NUM_CH)-1:0] first,
  output logic [$clog2(NUM_CH)-1:0] next
);
  localparam int CH_W = $clog2(NUM_CH);

  always_comb begin
    logic found;
    found = 1'b0;
    first = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && mask[i]) begin
        first = CH_W'(i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    logic found;
    int   idx;
    found = 1'b0;
    next  = cur;
    for (int off = 1; off <= NUM_CH; off++) begin
      idx = (int'(cur) + off) % NUM_CH;
      if (!found && mask[idx]) begin
        next  = CH_W'(idx);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_sar_ctrl.sv
module adc_sar_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic                      run,
  input  logic [NUM_CH-1:0]         eff_mask,
  input  logic                      cmp_ge,
  input  logic [$clog2(NUM_CH)-1:0] first_ch,
  input  logic [$clog2(NUM_CH)-1:0] next_ch,
  output logic [$clog2(NUM_CH)-1:0] cur_ch,
  output logic [RES_W-1:0]          trial_code,
  output logic                      wr_en,
  output logic [RES_W-1:0]          wr_data
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int BIT_W = $clog2(RES_W);

  scan_phase_e      phase_q, phase_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic [RES_W-1:0] acc_q, acc_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             abort;
  logic [RES_W-1:0] bit_mask;

  assign bit_mask = RES_W'(1) << bit_q;
  assign abort    = !run || (eff_mask == '0) ||
                    ((phase_q != PH_IDLE) && !eff_mask[ch_q]);

  always_comb begin
    phase_d = phase_q;
    ch_d    = ch_q;
    acc_d   = acc_q;
    bit_d   = bit_q;
    wr_en   = 1'b0;
    if (abort) begin
      phase_d = PH_IDLE;
      acc_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_SETTLE;
          ch_d    = first_ch;
          acc_d   = '0;
        end
        PH_SETTLE: if (tick) begin
          phase_d = PH_TRIAL;
          bit_d   = BIT_W'(RES_W - 1);
        end
        PH_TRIAL: if (tick) begin
          if (cmp_ge) acc_d = acc_q | bit_mask;
          if (bit_q == '0) phase_d = PH_WRITE;
          else             bit_d   = bit_q - 1'b1;
        end
        PH_WRITE: if (tick) begin
          wr_en   = 1'b1;
          ch_d    = next_ch;
          acc_d   = '0;
          phase_d = PH_SETTLE;
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ch_q    <= '0;
      acc_q   <= '0;
      bit_q   <= '0;
    end else begin
      phase_q <= phase_d;
      ch_q    <= ch_d;
      acc_q   <= acc_d;
      bit_q   <= bit_d;
    end
  end

  assign cur_ch     = ch_q;
  assign wr_data    = acc_q;
  assign trial_code = (phase_q == PH_TRIAL) ? (acc_q | bit_mask) : acc_q;
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [$clog2(NUM_CH)-1:0] wr_idx,
  input  logic [RES_W-1:0]          wr_data,
  output logic [NUM_CH*RES_W-1:0]   result_flat,
  output logic                      wr_strobe,
  output logic [$clog2(NUM_CH)-1:0] wr_chan
);
  localparam int CH_W = $clog2(NUM_CH);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic             hit;
    logic [RES_W-1:0] val_q;
    assign hit = wr_en && (wr_idx == CH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (hit) val_q <= wr_data;
    end
    assign result_flat[g*RES_W +: RES_W] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe <= 1'b0;
      wr_chan   <= '0;
    end else begin
      wr_strobe <= wr_en;
      if (wr_en) wr_chan <= wr_idx;
    end
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DIV_W-1:0]          div_code,
  input  logic [NUM_CH-1:0]         chan_en,
  input  logic                      run,
  input  logic                      cmp_ge,
  output logic [$clog2(NUM_CH)-1:0] mux_sel,
  output logic [RES_W-1:0]          trial_code,
  output logic [NUM_CH*RES_W-1:0]   result_flat,
  output logic                      wr_strobe,
  output logic [$clog2(NUM_CH)-1:0] wr_chan
);
  localparam int CH_W = $clog2(NUM_CH);

  logic              tick;
  logic [NUM_CH-1:0] eff_mask;
  logic [CH_W-1:0]   cur_ch, first_ch, next_ch;
  logic              wr_en;
  logic [RES_W-1:0]  wr_data;

  // channel 0 gates every other channel
  assign eff_mask = chan_en[0] ? chan_en : '0;

  adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .tick(tick)
  );

  adc_chan_pick #(.NUM_CH(NUM_CH)) u_pick (
    .mask(eff_mask), .cur(cur_ch), .first(first_ch), .next(next_ch)
  );

  adc_sar_ctrl #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .eff_mask(eff_mask),
    .cmp_ge(cmp_ge), .first_ch(first_ch), .next_ch(next_ch),
    .cur_ch(cur_ch), .trial_code(trial_code), .wr_en(wr_en), .wr_data(wr_data)
  );

  adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(cur_ch), .wr_data(wr_data),
    .result_flat(result_flat), .wr_strobe(wr_strobe), .wr_chan(wr_chan)
  );

  assign mux_sel = cur_ch;
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [DIV_W-1:0]          div_code,
  input logic [NUM_CH-1:0]         chan_en,
  input logic                      run,
  input logic [NUM_CH*RES_W-1:0]   result_flat,
  input logic                      wr_strobe,
  input logic [$clog2(NUM_CH)-1:0] wr_chan
);
  // R6: a write only follows an edge where run was high
  a_r6_no_write_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(run));

  // R3: a write only follows an edge where channel 0 was enabled
  a_r3_chan0_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(chan_en[0]));

  // R2: with ticks stopped for the whole previous cycle, no write
  a_r2_powersave: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> ($past(div_code) != '0));

  // R8: results move only together with the strobe
  a_r8_change_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |-> $stable(result_flat));

  // R10: other channels are untouched by a write
  for (genvar g = 0; g < NUM_CH; g++) begin : g_iso
    a_r10_other_slots: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && (int'(wr_chan) != g)) |->
        $stable(result_flat[g*RES_W +: RES_W]));
  end
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NUM_CH(NUM_CH), .RES_W(RES_W), .DIV_W(DIV_W))
  u_chk (.clk(clk), .rst_n(rst_n), .div_code(div_code), .chan_en(chan_en),
         .run(run), .result_flat(result_flat), .wr_strobe(wr_strobe),
         .wr_chan(wr_chan));

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int RW  = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    div_code;
  logic [3:0]    chan_en;
  logic          run;
  logic          cmp_ge;
  logic [1:0]    mux_sel;
  logic [9:0]    trial_code;
  logic [39:0]   result_flat;
  logic          wr_strobe;
  logic [1:0]    wr_chan;
  logic [9:0]    vin [NCH];

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign cmp_ge = (vin[mux_sel] >= trial_code);

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .div_code(div_code), .chan_en(chan_en),
    .run(run), .cmp_ge(cmp_ge), .mux_sel(mux_sel), .trial_code(trial_code),
    .result_flat(result_flat), .wr_strobe(wr_strobe), .wr_chan(wr_chan)
  );

  function automatic logic [9:0] res(int i);
    return result_flat[i*RW +: RW];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits on negedges for a strobe; n = cycles waited, -1 on timeout
  task automatic wait_strobe(int limit, output int n);
    n = -1;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      if (wr_strobe) begin n = c; break; end
    end
  endtask

  task automatic idle_count(int cycles, output int seen);
    seen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (wr_strobe) seen++;
    end
  endtask

  task automatic t_reset;
    int seen;
    rst_n = 1'b0; div_code = 3'd0; chan_en = 4'd0; run = 1'b0;
    for (int i = 0; i < NCH; i++) vin[i] = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NCH; i++) check("R9 result zero", res(i), 0);
    idle_count(40, seen);
    check("R9 no strobe", seen, 0);
  endtask

  task automatic t_scan_order;
    int n;
    int exp_seq [5] = '{0, 1, 2, 3, 0};
    vin[0] = 10'h000; vin[1] = 10'h3FF; vin[2] = 10'h155; vin[3] = 10'h2AA;
    div_code = 3'd1; chan_en = 4'b1111; run = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_strobe(200, n);
      check("R4 order", wr_chan, exp_seq[k]);
      check("R5 code", res(exp_seq[k]), vin[exp_seq[k]]);
      if (k > 0) check("R1 spacing div1", n, 12);
    end
    @(negedge clk);
    check("R8 strobe one cycle", wr_strobe, 0);
  endtask

  task automatic t_skip;
    int n;
    int exp_seq [4] = '{2, 3, 0, 2};
    vin[0] = 10'd1; vin[2] = 10'd512; vin[3] = 10'd511;
    chan_en = 4'b1101;
    wait_strobe(200, n);
    for (int k = 0; k < 4; k++) begin
      wait_strobe(200, n);
      check("R4 skip disabled", wr_chan, exp_seq[k]);
      check("R5 code", res(exp_seq[k]), vin[exp_seq[k]]);
    end
  endtask

  task automatic t_gate;
    int seen;
    logic [39:0] snap;
    chan_en = 4'b1110;
    @(negedge clk);
    snap = result_flat;
    vin[1] = 10'd7;
    idle_count(300, seen);
    check("R3 no conversion without ch0", seen, 0);
    check("R3 results held", int'(result_flat == snap), 1);
  endtask

  task automatic t_divider(input logic [2:0] code);
    int n;
    int exp_n;
    exp_n = 12 * (1 << (code - 1));
    chan_en = 4'b0001; vin[0] = 10'd333; div_code = code;
    wait_strobe(2000, n);
    wait_strobe(2000, n);
    check("R1 spacing", n, exp_n);
    check("R5 code", res(0), 333);
  endtask

  task automatic t_powersave;
    int seen;
    logic [39:0] snap;
    div_code = 3'd0;
    @(negedge clk);
    snap = result_flat;
    vin[0] = 10'd900;
    idle_count(2000, seen);
    check("R2 no writes at code 0", seen, 0);
    check("R2 results held", int'(result_flat == snap), 1);
  endtask

  task automatic t_freeze;
    int n, seen;
    div_code = 3'd1; chan_en = 4'b0001; vin[0] = 10'd100; run = 1'b1;
    wait_strobe(200, n);
    wait_strobe(200, n);
    check("R5 code", res(0), 100);
    repeat (5) @(negedge clk);
    run = 1'b0; vin[0] = 10'd700;
    idle_count(150, seen);
    check("R6 no writes frozen", seen, 0);
    check("R6 result held", res(0), 100);
    run = 1'b1;
    wait_strobe(200, n);
    check("R7 fresh conversion", res(0), 700);
    check("R8 strobe index", wr_chan, 0);
  endtask

  task automatic t_isolation;
    int n;
    logic [9:0] keep1;
    div_code = 3'd1; chan_en = 4'b0011; vin[0] = 10'd5; vin[1] = 10'd1000;
    wait_strobe(200, n);
    wait_strobe(200, n);
    wait_strobe(200, n);
    if (wr_chan == 2'd1) wait_strobe(200, n);
    keep1 = res(1);
    check("R10 ch0 write", wr_chan, 0);
    check("R10 other kept", keep1, 1000);
    check("R5 ch0 code", res(0), 5);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_scan_order();
    t_skip();
    t_gate();
    t_divider(3'd1);
    t_divider(3'd3);
    t_divider(3'd7);
    t_powersave();
    t_freeze();
    t_isolation();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule